// File: doc/BRIEF.md
# Nibble-Serial Map CRC-16 Engine

This block computes the 16-bit check value that guards the topology and speed map images of a serial-bus node. A client pulses `start` with the number of 32-bit words to cover, then hands the words over one at a time on a valid/data pair whenever `ready` is high. The engine works through each word four bits per clock, beginning with the top nibble, and folds each nibble into the check state. It uses the nibble-wide form of the x^16+x^12+x^5+1 polynomial.

Each word occupies the engine for eight clocks, and `ready` stays low during that time. After the last nibble of the last word, `done` pulses for one cycle. The result stays on `crc` until the next `start`. For a topology map, the client passes the self-ID count plus two as the length.

Top module: `map_crc16`

## Requirements
- R1: After reset, `done` is 0, `ready` is 0 and `crc` is 0x0000.
- R2: A `start` pulse clears the check state, so `crc` reads 0x0000 on the cycle after `start`. If `len` is nonzero, `ready` is 1 on that same cycle.
- R3: For each nibble n, the nibbles being taken from a word at bit positions 31:28 first and 3:0 last, the state c updates as s = (c[15:12] XOR n) and c' = (c<<4) XOR (s<<12) XOR (s<<5) XOR s. Only the low 16 bits are kept.
- R4: After exactly `len` words, the final `crc` equals the update of R3 applied to all 8*`len` nibbles in order, starting from 0.
- R5: A word is accepted on a clock edge where `ready` and `word_valid` are both 1. `ready` is then 0 for exactly 8 cycles. It returns to 1 afterwards if more words remain.
- R6: `done` is 1 for exactly one cycle: the 9th cycle after the edge that accepted the last word. It is 0 at every other time.
- R7: Once `done` has pulsed, `crc` holds its value until the next `start`.
- R8: If `len` is 0, `done` is 1 on the cycle after `start`, `crc` is 0x0000, and `ready` stays 0.
- R9: `word_valid` while `ready` is 0 is ignored and does not change the result.
- R10: A `start` during a run abandons that run. The state clears and the new length is counted from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new check over `len` words |
| len | input | LEN_W | Number of words, sampled with `start` |
| word_valid | input | 1 | Offered word is valid |
| word_data | input | WORD_W | Offered word, big-endian nibble order |
| ready | output | 1 | Engine can take a word |
| done | output | 1 | One-cycle pulse when the last word is folded in |
| crc | output | 16 | Check value, held after completion |

## Verification
A wrong nibble order, a wrong feedback term or a missing truncation corrupts `crc` on the same `done` pulse that ends a single-word run. Any such fault is therefore visible within nine cycles of the word being offered. A miscounted word or nibble counter shows up sooner, as `ready` rising or `done` pulsing one cycle off from the window the bench expects. A datapath that wrongly accepts a word while busy changes the final value in runs with injected spurious words. A run that fails to clear on `start` leaves a nonzero value visible on the cycle after the pulse.

// File: rtl/map_crc16_pkg.sv
package map_crc16_pkg;
  localparam int CRC_W = 16;
  localparam int NIB_W = 4;
  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/mcrc_nibble_step.sv
module mcrc_nibble_step
  import map_crc16_pkg::*;
(
  input  crc_t cur,
  input  nib_t nib,
  output crc_t nxt
);
  nib_t fb;
  // Feedback nibble from the state's top four bits; bits above 15 never
  // reach the low half, so truncating each step equals truncating per word.
  assign fb  = cur[15:12] ^ nib;
  assign nxt = {cur[11:0], 4'b0000}
             ^ {fb, 12'h000}
             ^ {7'b0000000, fb, 5'b00000}
             ^ {12'h000, fb};
endmodule

// File: rtl/mcrc_datapath.sv
module mcrc_datapath
  import map_crc16_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic              step_en,
  input  logic [WORD_W-1:0] word,
  output crc_t              crc_q
);
  logic [WORD_W-1:0] shreg;
  crc_t              nxt;

  mcrc_nibble_step u_step (
    .cur (crc_q),
    .nib (shreg[WORD_W-1 -: NIB_W]),
    .nxt (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '0;
      shreg <= '0;
    end else if (clear) begin
      crc_q <= '0;
    end else if (load) begin
      shreg <= word;
    end else if (step_en) begin
      crc_q <= nxt;
      shreg <= {shreg[WORD_W-NIB_W-1:0], {NIB_W{1'b0}}};
    end
  end

  // R2: state cleared after a start
  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (rst)
    clear |=> (crc_q == '0));
  // R7: state does not move unless stepping or clearing
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !clear) |=> $stable(crc_q));
endmodule

// File: rtl/mcrc_control.sv
module mcrc_control #(
  parameter int NIBS  = 8,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             word_valid,
  output logic             load,
  output logic             step_en,
  output logic             ready,
  output logic             done
);
  localparam int CNT_W = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(NIBS - 1);

  logic             busy;
  logic             shifting;
  logic [CNT_W-1:0] nib_cnt;
  logic [LEN_W-1:0] words_left;

  assign ready   = busy && !shifting;
  assign load    = ready && word_valid && !start;
  assign step_en = shifting && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      shifting   <= 1'b0;
      nib_cnt    <= '0;
      words_left <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy       <= (len != '0);
        shifting   <= 1'b0;
        nib_cnt    <= '0;
        words_left <= len;
        done       <= (len == '0);
      end else if (load) begin
        shifting <= 1'b1;
        nib_cnt  <= '0;
      end else if (shifting) begin
        nib_cnt <= nib_cnt + 1'b1;
        if (nib_cnt == LAST_NIB) begin
          shifting   <= 1'b0;
          words_left <= words_left - 1'b1;
          if (words_left == LEN_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: an accepted word drops ready
  a_r5_ready_drops: assert property (@(posedge clk) disable iff (rst)
    load |=> !ready);
  // R8: empty run completes at once
  a_r8_zero_len: assert property (@(posedge clk) disable iff (rst)
    (start && len == '0) |=> (done && !ready));
endmodule

// File: rtl/map_crc16.sv
module map_crc16
  import map_crc16_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              ready,
  output logic              done,
  output logic [15:0]       crc
);
  localparam int NIBS = WORD_W / NIB_W;

  logic load, step_en;
  crc_t crc_q;

  mcrc_control #(.NIBS(NIBS), .LEN_W(LEN_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .len        (len),
    .word_valid (word_valid),
    .load       (load),
    .step_en    (step_en),
    .ready      (ready),
    .done       (done)
  );

  mcrc_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .clear   (start),
    .load    (load),
    .step_en (step_en),
    .word    (word_data),
    .crc_q   (crc_q)
  );

  assign crc = crc_q;
endmodule

// File: tb/map_crc16_test.sv
module map_crc16_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [9:0]  len = '0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        ready, done;
  logic [15:0] crc;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0] words [0:15];

  map_crc16 uut (
    .clk(clk), .rst(rst), .start(start), .len(len),
    .word_valid(word_valid), .word_data(word_data),
    .ready(ready), .done(done), .crc(crc)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [15:0] ref_word(input logic [15:0] c_in, input logic [31:0] w);
    int c = c_in;
    for (int sh = 28; sh >= 0; sh -= 4) begin
      int s;
      s = ((c >> 12) ^ (w >> sh)) & 15;
      c = (c << 4) ^ (s << 12) ^ (s << 5) ^ s;
    end
    return c[15:0];
  endfunction

  function automatic logic [15:0] ref_seq(input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++) c = ref_word(c, words[i]);
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_start(input int n);
    @(negedge clk);
    start = 1'b1;
    len = 10'(n);
    @(negedge clk);
    start = 1'b0;
    chk("R2 crc cleared", {16'h0, crc}, 32'h0);
    chk("R2 ready after start", {31'h0, ready}, {31'h0, n != 0});
  endtask

  task automatic feed_word(input logic [31:0] w, input bit last, input bit noise,
                           input logic [15:0] exp_final);
    int gap = $urandom_range(0, 2);
    for (int g = 0; g < gap; g++) @(negedge clk);
    chk("R5 ready before word", {31'h0, ready}, 32'h1);
    word_valid = 1'b1;
    word_data = w;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      chk("R5 ready low while busy", {31'h0, ready}, 32'h0);
      chk("R6 done low mid word", {31'h0, done}, 32'h0);
      word_valid = noise && (i < 8);
      word_data = $urandom;
    end
    word_valid = 1'b0;
    @(negedge clk);
    chk("R6 done at end", {31'h0, done}, {31'h0, last});
    chk("R5 ready after word", {31'h0, ready}, {31'h0, !last});
    if (last) begin
      chk("R4 final crc", {16'h0, crc}, {16'h0, exp_final});
      @(negedge clk);
      chk("R6 done single cycle", {31'h0, done}, 32'h0);
      repeat (3) @(negedge clk);
      chk("R7 crc held", {16'h0, crc}, {16'h0, exp_final});
    end
  endtask

  task automatic run(input int n, input bit noise);
    logic [15:0] e = ref_seq(n);
    do_start(n);
    for (int i = 0; i < n; i++) feed_word(words[i], i == n - 1, noise, e);
  endtask

  initial begin
    void'($urandom(32'd1394));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset done", {31'h0, done}, 32'h0);
    chk("R1 reset ready", {31'h0, ready}, 32'h0);
    chk("R1 reset crc", {16'h0, crc}, 32'h0);

    // R3 single words, directed
    words[0] = 32'h0000_0000; run(1, 0);
    words[0] = 32'h3133_3934; run(1, 0);
    chk("R3 single word value", {16'h0, crc}, {16'h0, ref_word(16'h0, 32'h3133_3934)});
    words[0] = 32'hF000_0000; run(1, 0);
    words[0] = 32'h0000_000F; run(1, 0);
    words[0] = 32'hFFFF_FFFF; run(1, 0);

    // R8 empty run
    @(negedge clk);
    start = 1'b1; len = '0;
    @(negedge clk);
    start = 1'b0;
    chk("R8 done next cycle", {31'h0, done}, 32'h1);
    chk("R8 crc zero", {16'h0, crc}, 32'h0);
    chk("R8 ready low", {31'h0, ready}, 32'h0);
    @(negedge clk);
    chk("R8 done pulse ends", {31'h0, done}, 32'h0);

    // R4 random multi-word, R9 with spurious valids
    for (int t = 0; t < 12; t++) begin
      int n = $urandom_range(1, 16);
      for (int i = 0; i < n; i++) words[i] = $urandom;
      run(n, t[0]);
    end
    // R9 directed: noise during every word of a 5-word run
    for (int i = 0; i < 5; i++) words[i] = 32'hA5A5_0000 + i;
    run(5, 1);

    // R10 restart mid-run
    do_start(3);
    word_valid = 1'b1; word_data = 32'hDEAD_BEEF;
    repeat (4) @(negedge clk);
    word_valid = 1'b0;
    words[0] = 32'h1234_5678;
    do_start(1);
    feed_word(words[0], 1, 0, ref_word(16'h0, 32'h1234_5678));
    chk("R10 restart result", {16'h0, crc}, {16'h0, ref_word(16'h0, 32'h1234_5678)});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule